// File: doc/BRIEF.md
# Bit-Plane Graphics Overlay Mixer

This block merges a three-plane graphics frame buffer with the pixel stream of a character layer. The frame buffer keeps one bit per pixel in each of a red, a green and a blue plane, so every graphics pixel is one of eight colours. The beam position arrives as a horizontal and a vertical pixel counter. From these the block forms one byte address that is shared by the three plane memories, and it picks the current pixel out of each byte that comes back.

Each plane bit is combined with the matching bit of the character pixel. A two-bit mode selects the operator: OR, AND, NAND or XOR. When the combined colour is zero on every plane, the block outputs the background colour of the character cell. Outside the visible area the output is black.

The plane memories are assumed to return data one clock after the address. The block delays its other inputs by the same clock, so that they line up with the returned bytes. The result is registered.

Top module: `gfx_overlay_mixer`

## Requirements
- R1: `plane_addr` equals `v_cnt * (H_PIXELS/8) + h_cnt/8` as a combinational function of the counters in the same cycle. Each address holds 8 horizontal pixels.
- R2: The pixel in a plane byte is selected by `h_cnt[2:0]`. Value 0 selects bit 7, the leftmost pixel, and value 7 selects bit 0.
- R3: `blend_mode` 2'b00 ORs each plane bit with its character bit, and 2'b01 ANDs them.
- R4: `blend_mode` 2'b10 gives the NAND of each plane bit and its character bit, and 2'b11 gives their XOR.
- R5: When the combined colour is 3'b000, `pix_rgb` carries `bg_rgb` instead.
- R6: While the display-enable input was low for the pixel, `pix_rgb` is 3'b000, whatever the planes, the character pixel or the background.
- R7: A pixel's result appears on `pix_rgb` after the second rising edge that follows the edge at which its counters and side inputs were presented. The plane bytes for that pixel are taken one edge after its address.
- R8: While `rst_n` is low, `pix_rgb` is 3'b000. Colour bits are packed as bit 2 red, bit 1 green, bit 0 blue in `chr_rgb`, `bg_rgb` and `pix_rgb`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_cnt | input | HW | Horizontal pixel counter |
| v_cnt | input | VW | Vertical line counter |
| de_in | input | 1 | Display enable for the current pixel |
| blend_mode | input | 2 | Operator: 00 OR, 01 AND, 10 NAND, 11 XOR |
| chr_rgb | input | 3 | Character-layer pixel, one bit per plane |
| bg_rgb | input | 3 | Cell background colour |
| plane_addr | output | AW | Byte address shared by the three plane memories |
| red_byte | input | 8 | Red plane byte, returned one clock after the address |
| grn_byte | input | 8 | Green plane byte, returned one clock after the address |
| blu_byte | input | 8 | Blue plane byte, returned one clock after the address |
| pix_rgb | output | 3 | Composed pixel colour |

## Verification
The address is due in the same cycle as the counters. The bench checks it one time step after it drives them on the falling edge. The composed colour is due two rising edges after the stimulus, so the bench carries each expected value through a two-stage queue and compares it on the second falling edge that follows. A directed test confirms that the output has not yet changed after the first edge and has changed after the second. Expected colours come from an arithmetic model of plane memory content, swept over every pixel of a small frame in all four modes.

// File: rtl/gfx_overlay_mixer.sv
module gfx_overlay_mixer #(
  parameter int H_PIXELS = 64,
  parameter int V_LINES  = 16,
  localparam int HW  = $clog2(H_PIXELS),
  localparam int VW  = $clog2(V_LINES),
  localparam int BPL = H_PIXELS / 8,
  localparam int AW  = $clog2(BPL * V_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_cnt,
  input  logic [VW-1:0] v_cnt,
  input  logic          de_in,
  input  logic [1:0]    blend_mode,
  input  logic [2:0]    chr_rgb,
  input  logic [2:0]    bg_rgb,
  output logic [AW-1:0] plane_addr,
  input  logic [7:0]    red_byte,
  input  logic [7:0]    grn_byte,
  input  logic [7:0]    blu_byte,
  output logic [2:0]    pix_rgb
);

  logic [2:0] sel_q;
  logic [2:0] chr_q;
  logic [2:0] bg_q;
  logic [1:0] mode_q;
  logic       de_q;
  logic [2:0] gfx_bit;
  logic [2:0] mix;
  logic [7:0] plane [3];

  assign plane_addr = AW'(v_cnt * BPL + (h_cnt >> 3));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      chr_q  <= '0;
      bg_q   <= '0;
      mode_q <= '0;
      de_q   <= 1'b0;
    end else begin
      sel_q  <= h_cnt[2:0];
      chr_q  <= chr_rgb;
      bg_q   <= bg_rgb;
      mode_q <= blend_mode;
      de_q   <= de_in;
    end
  end

  assign plane[2] = red_byte;
  assign plane[1] = grn_byte;
  assign plane[0] = blu_byte;

  for (genvar p = 0; p < 3; p++) begin : g_plane
    assign gfx_bit[p] = plane[p][3'd7 - sel_q];
    always_comb begin
      unique case (mode_q)
        2'b00:   mix[p] = gfx_bit[p] | chr_q[p];
        2'b01:   mix[p] = gfx_bit[p] & chr_q[p];
        2'b10:   mix[p] = ~(gfx_bit[p] & chr_q[p]);
        default: mix[p] = gfx_bit[p] ^ chr_q[p];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pix_rgb <= '0;
    else if (!de_q)     pix_rgb <= '0;
    else if (mix == '0) pix_rgb <= bg_q;
    else                pix_rgb <= mix;
  end

endmodule

// File: rtl/gfx_overlay_mixer_chk.sv
module gfx_overlay_mixer_chk #(
  parameter int HW = 6,
  parameter int VW = 4,
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] h_cnt,
  input logic [VW-1:0] v_cnt,
  input logic [AW-1:0] plane_addr,
  input logic [2:0]    pix_rgb,
  input logic          de_q,
  input logic [2:0]    chr_q,
  input logic [2:0]    bg_q,
  input logic [1:0]    mode_q
);

  AST_ADDR_SAME_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (v_cnt == $past(v_cnt) && (h_cnt >> 3) == ($past(h_cnt) >> 3)) |-> plane_addr == $past(plane_addr)); // R1

  AST_OFF_IS_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    !de_q |=> pix_rgb == 3'b000); // R6

  AST_NEVER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (de_q && bg_q != 3'b000) |=> pix_rgb != 3'b000); // R5

  AST_OR_COVERS_CHR: assert property (@(posedge clk) disable iff (!rst_n)
    (de_q && mode_q == 2'b00 && chr_q != 3'b000) |=> (pix_rgb & $past(chr_q)) == $past(chr_q)); // R3

  AST_AND_WITHIN_CHR: assert property (@(posedge clk) disable iff (!rst_n)
    (de_q && mode_q == 2'b01) |=> ((pix_rgb & ~$past(chr_q)) == 3'b000 || pix_rgb == $past(bg_q))); // R3

endmodule

bind gfx_overlay_mixer gfx_overlay_mixer_chk #(.HW(HW), .VW(VW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt), .plane_addr(plane_addr),
  .pix_rgb(pix_rgb), .de_q(de_q), .chr_q(chr_q), .bg_q(bg_q), .mode_q(mode_q)
);

// File: tb/test_gfx_overlay_mixer.sv
`timescale 1ns/1ps
module test_gfx_overlay_mixer;
  localparam int H = 64;
  localparam int V = 16;
  localparam int HW = $clog2(H);
  localparam int VW = $clog2(V);
  localparam int AW = $clog2(H / 8 * V);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HW-1:0] h_cnt = '0;
  logic [VW-1:0] v_cnt = '0;
  logic de_in = 1'b0;
  logic [1:0] blend_mode = '0;
  logic [2:0] chr_rgb = '0, bg_rgb = '0;
  logic [AW-1:0] plane_addr;
  logic [7:0] red_byte = '0, grn_byte = '0, blu_byte = '0;
  logic [2:0] pix_rgb;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [2:0] e1, e2;
  bit v1 = 0, v2 = 0;
  string t1, t2;

  always #5 clk = ~clk;

  gfx_overlay_mixer #(.H_PIXELS(H), .V_LINES(V)) i_gfx_overlay_mixer (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt), .de_in(de_in),
    .blend_mode(blend_mode), .chr_rgb(chr_rgb), .bg_rgb(bg_rgb), .plane_addr(plane_addr),
    .red_byte(red_byte), .grn_byte(grn_byte), .blu_byte(blu_byte), .pix_rgb(pix_rgb)
  );

  function automatic logic [7:0] mem_byte(int p, int a);
    return 8'((a * (29 + p * 14) + p * 91 + 7) & 255);
  endfunction

  always @(posedge clk) begin
    red_byte <= mem_byte(2, int'(plane_addr));
    grn_byte <= mem_byte(1, int'(plane_addr));
    blu_byte <= mem_byte(0, int'(plane_addr));
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int h, int v, int mode, int chr, int bg, bit de);
    int a, mix, bit_g, bit_c, res;
    string tag;
    @(negedge clk);
    if (v2) check(t2, int'(pix_rgb), int'(e2));
    e2 = e1; v2 = v1; t2 = t1;
    h_cnt = HW'(h); v_cnt = VW'(v); blend_mode = 2'(mode);
    chr_rgb = 3'(chr); bg_rgb = 3'(bg); de_in = de;
    a = v * (H / 8) + h / 8;
    mix = 0;
    for (int p = 0; p < 3; p++) begin
      bit_g = (mem_byte(p, a) >> (7 - (h % 8))) & 1;
      bit_c = (chr >> p) & 1;
      case (mode)
        0: res = bit_g | bit_c;
        1: res = bit_g & bit_c;
        2: res = 1 - (bit_g & bit_c);
        default: res = bit_g ^ bit_c;
      endcase
      mix |= res << p;
    end
    if (!de)            begin e1 = 3'b000;   tag = "R6"; end
    else if (mix == 0)  begin e1 = 3'(bg);   tag = "R5"; end
    else if (mode < 2)  begin e1 = 3'(mix);  tag = "R2,R3,R7"; end
    else                begin e1 = 3'(mix);  tag = "R2,R4,R7"; end
    v1 = 1; t1 = tag;
    #1 check("R1", int'(plane_addr), a);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8: reset holds output black even with live inputs
    de_in = 1'b1; chr_rgb = 3'b111; bg_rgb = 3'b101;
    repeat (3) @(negedge clk);
    check("R8", int'(pix_rgb), 0);
    @(negedge clk);
    check("R8", int'(pix_rgb), 0);
    rst_n = 1'b1;

    for (int m = 0; m < 4; m++)
      for (int v = 0; v < V; v++)
        for (int h = 0; h < H; h++)
          step(h, v, m, (h ^ (v * 3) ^ m) & 7, (h + v * 5) & 7, (h % 11) != 3);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);

    // R7: directed latency probe
    @(negedge clk);
    de_in = 1'b1; blend_mode = 2'b00; chr_rgb = 3'b111; bg_rgb = 3'b000;
    @(negedge clk);
    check("R7", int'(pix_rgb), 0);
    @(negedge clk);
    check("R7", int'(pix_rgb), 7);

    // R6: display off masks a full-colour pixel
    de_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R6", int'(pix_rgb), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule